// File: doc/BRIEF.md
# Ethernet MAC Interrupt Status and Mask Unit

This block gathers six interrupt causes of an Ethernet MAC into one 8-bit status byte, gates them with an 8-bit host mask, and drives a single interrupt request line. Four causes are live levels: received frame waiting, transmit fault, buffer allocation done, and protocol-handler event. Each of these reads back as the current state of its source and drops when the source drops. The other two are one-cycle event pulses: transmit queue drained and receive overrun. The block latches each of them until the host acknowledges it by writing a one to its bit.

The host reaches both registers through a simple write port. A select bit picks the status byte or the mask byte. Both bytes are always visible as outputs. A common service routine saves the mask, writes zero to it so the request line drops while it works through the status bits, and then restores the mask.

Top module: `mac_irq_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the mask reads 0x00, both latched status bits read 0 and the request line is low.
- R2: The status byte has this bit layout: bit 0 receive frame available, bit 1 transmit fault, bit 2 transmit queue drained, bit 3 allocation done, bit 4 receive overrun, bit 5 protocol event. Bits 7 and 6 always read 0.
- R3: Status bits 0, 1, 3 and 5 equal their source inputs in the same cycle, and no write to the status byte changes them.
- R4: A pulse on the drained or overrun event input sets status bit 2 or 4 at the next clock edge. The bit then holds until it is acknowledged.
- R5: A status write (select = 0) with a one in bit 2 or bit 4 clears that latched bit at the next edge. A zero in that position leaves the bit unchanged.
- R6: If an event pulse arrives in the same cycle as an acknowledge of its own bit, the bit stays set.
- R7: A mask write (select = 1) loads all eight data bits at the next edge. A status write never changes the mask, and a mask write never changes the status byte.
- R8: The request line is high exactly when some bit is set both in the status byte and in the mask, with no added delay.
- R9: A mask of zero keeps the request line low while status bits are pending, and those bits stay readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_avail_i | input | 1 | Level: a received frame is waiting |
| tx_err_i | input | 1 | Level: transmit fault present |
| alloc_done_i | input | 1 | Level: buffer allocation result pending |
| proto_evt_i | input | 1 | Level: protocol-handler event present |
| tx_empty_evt_i | input | 1 | Pulse: transmit queue drained |
| rx_ovrn_evt_i | input | 1 | Pulse: receive overrun |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 status, 1 mask |
| reg_wdata_i | input | 8 | Write data |
| status_o | output | 8 | Status byte |
| mask_o | output | 8 | Mask byte |
| irq_o | output | 1 | Interrupt request |

## Verification
The directed patterns cover several cases separately. Writing ones to the level bits shows that those bits ignore acknowledges. Acknowledging the wrong latched bit shows that the clear is per bit. An event that coincides with its own acknowledge shows which side wins. Setting the mask to zero with causes pending shows that gating is separate from status. A long random phase then mixes levels, pulses, acknowledges and mask writes in every combination. A cycle-by-cycle reference model checks that the request line follows the masked status in the same cycle and that the latched bits change only on the following edge.

// File: rtl/mac_irq_pkg.sv
package mac_irq_pkg;
    localparam int STAT_W = 8;

    localparam int BIT_RX_AVAIL = 0;
    localparam int BIT_TX_ERR   = 1;
    localparam int BIT_TX_EMPTY = 2;
    localparam int BIT_ALLOC    = 3;
    localparam int BIT_RX_OVRN  = 4;
    localparam int BIT_PROTO    = 5;

    // Positions held until a write-one acknowledge; others are live levels or zero.
    localparam logic [STAT_W-1:0] W1C_BITS =
        STAT_W'((1 << BIT_TX_EMPTY) | (1 << BIT_RX_OVRN));

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_MASK   = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic pend;
    } w1c_state_t;
endpackage

// File: rtl/mac_irq_w1c_bit.sv
module mac_irq_w1c_bit
    import mac_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic clr_i,
    output logic q_o
);
    w1c_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) st_d.pend = 1'b0;
        if (evt_i) st_d.pend = 1'b1;   // a fresh event outranks the acknowledge
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.pend;
endmodule

// File: rtl/mac_irq_mask_reg.sv
module mac_irq_mask_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] mask_o
);
    typedef struct packed {
        logic [W-1:0] mask;
    } mask_state_t;

    mask_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) st_d.mask = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_o = st_q.mask;
endmodule

// File: rtl/mac_irq_combine.sv
module mac_irq_combine #(
    parameter int W = 8
) (
    input  logic [W-1:0] status_i,
    input  logic [W-1:0] mask_i,
    output logic         irq_o
);
    logic [W-1:0] gated;

    always_comb begin
        gated = status_i & mask_i;
        irq_o = |gated;
    end
endmodule

// File: rtl/mac_irq_ctrl.sv
module mac_irq_ctrl
    import mac_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_avail_i,
    input  logic              tx_err_i,
    input  logic              alloc_done_i,
    input  logic              proto_evt_i,
    input  logic              tx_empty_evt_i,
    input  logic              rx_ovrn_evt_i,
    input  logic              reg_wr_i,
    input  logic              reg_sel_i,
    input  logic [STAT_W-1:0] reg_wdata_i,
    output logic [STAT_W-1:0] status_o,
    output logic [STAT_W-1:0] mask_o,
    output logic              irq_o
);
    logic [STAT_W-1:0] src_vec;
    logic              stat_wr, mask_wr;

    always_comb begin
        src_vec               = '0;
        src_vec[BIT_RX_AVAIL] = rx_avail_i;
        src_vec[BIT_TX_ERR]   = tx_err_i;
        src_vec[BIT_TX_EMPTY] = tx_empty_evt_i;
        src_vec[BIT_ALLOC]    = alloc_done_i;
        src_vec[BIT_RX_OVRN]  = rx_ovrn_evt_i;
        src_vec[BIT_PROTO]    = proto_evt_i;
        stat_wr = reg_wr_i && (reg_sel_e'(reg_sel_i) == SEL_STATUS);
        mask_wr = reg_wr_i && (reg_sel_e'(reg_sel_i) == SEL_MASK);
    end

    for (genvar g = 0; g < STAT_W; g++) begin : g_stat
        if (W1C_BITS[g]) begin : g_latched
            mac_irq_w1c_bit u_bit (
                .clk   (clk),
                .rst_n (rst_n),
                .evt_i (src_vec[g]),
                .clr_i (stat_wr & reg_wdata_i[g]),
                .q_o   (status_o[g])
            );
        end else begin : g_live
            assign status_o[g] = src_vec[g];
        end
    end

    mac_irq_mask_reg #(.W(STAT_W)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (mask_wr),
        .wdata_i (reg_wdata_i),
        .mask_o  (mask_o)
    );

    mac_irq_combine #(.W(STAT_W)) u_comb (
        .status_i (status_o),
        .mask_i   (mask_o),
        .irq_o    (irq_o)
    );
endmodule

// File: rtl/mac_irq_chk.sv
module mac_irq_chk
    import mac_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              rx_avail_i,
    input logic              tx_err_i,
    input logic              alloc_done_i,
    input logic              proto_evt_i,
    input logic              tx_empty_evt_i,
    input logic              rx_ovrn_evt_i,
    input logic              reg_wr_i,
    input logic              reg_sel_i,
    input logic [STAT_W-1:0] reg_wdata_i,
    input logic [STAT_W-1:0] status_o,
    input logic [STAT_W-1:0] mask_o,
    input logic              irq_o
);
    logic ack2, ack4;
    assign ack2 = reg_wr_i && !reg_sel_i && reg_wdata_i[BIT_TX_EMPTY];
    assign ack4 = reg_wr_i && !reg_sel_i && reg_wdata_i[BIT_RX_OVRN];

    assert_top_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[7:6] == 2'b00);

    assert_levels_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[BIT_RX_AVAIL] == rx_avail_i && status_o[BIT_TX_ERR] == tx_err_i &&
        status_o[BIT_ALLOC] == alloc_done_i && status_o[BIT_PROTO] == proto_evt_i);

    assert_empty_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty_evt_i |=> status_o[BIT_TX_EMPTY]);

    assert_ovrn_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovrn_evt_i |=> status_o[BIT_RX_OVRN]);

    assert_empty_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_empty_evt_i && !ack2) |=> $stable(status_o[BIT_TX_EMPTY]));

    assert_empty_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack2 && !tx_empty_evt_i) |=> !status_o[BIT_TX_EMPTY]);

    assert_ovrn_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack4 && !rx_ovrn_evt_i) |=> !status_o[BIT_RX_OVRN]);

    assert_evt_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack4 && rx_ovrn_evt_i) |=> status_o[BIT_RX_OVRN]);

    assert_mask_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_sel_i) |=> mask_o == $past(reg_wdata_i));

    assert_mask_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_i && reg_sel_i) |=> $stable(mask_o));

    assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == |(status_o & mask_o));

    assert_zero_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_o == '0) |-> !irq_o);
endmodule

bind mac_irq_ctrl mac_irq_chk u_chk (.*);

// File: tb/test_mac_irq_ctrl.sv
module test_mac_irq_ctrl;
    localparam int PER = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx, txerr, alloc, proto, emp, ovr;
    logic       wr, sel;
    logic [7:0] wd;
    logic [7:0] status_o, mask_o;
    logic       irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // behavioural reference state
    bit       m_emp, m_ovr;
    bit [7:0] m_mask;

    always #(PER/2) clk = ~clk;

    mac_irq_ctrl i_mac_irq_ctrl (
        .clk(clk), .rst_n(rst_n),
        .rx_avail_i(rx), .tx_err_i(txerr), .alloc_done_i(alloc), .proto_evt_i(proto),
        .tx_empty_evt_i(emp), .rx_ovrn_evt_i(ovr),
        .reg_wr_i(wr), .reg_sel_i(sel), .reg_wdata_i(wd),
        .status_o(status_o), .mask_o(mask_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit [7:0] exp_status();
        return {2'b00, proto, m_ovr, alloc, m_emp, txerr, rx};
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_emp <= 0; m_ovr <= 0; m_mask <= 0;
        end else begin
            if (wr && sel) m_mask <= wd;
            if (emp) m_emp <= 1;
            else if (wr && !sel && wd[2]) m_emp <= 0;
            if (ovr) m_ovr <= 1;
            else if (wr && !sel && wd[4]) m_ovr <= 0;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 status", status_o, exp_status());
            chk("R7 mask", mask_o, m_mask);
            chk("R8 irq", {7'b0, irq_o}, {7'b0, |(exp_status() & m_mask)});
        end
    end

    // src: [0]rx [1]txerr [2]empty pulse [3]alloc [4]overrun pulse [5]proto
    task automatic cyc(input logic [5:0] src, input logic w, input logic s, input logic [7:0] d);
        @(posedge clk);
        #(PER/4);
        {proto, ovr, alloc, emp, txerr, rx} = src;
        wr = w; sel = s; wd = d;
        @(negedge clk);
    endtask

    initial begin
        {proto, ovr, alloc, emp, txerr, rx} = '0;
        wr = 0; sel = 0; wd = '0;
        repeat (3) @(negedge clk);
        chk("R1 status in reset", status_o, 8'h00);
        chk("R1 mask in reset", mask_o, 8'h00);
        chk("R1 irq in reset", {7'b0, irq_o}, 8'h00);
        rst_n = 1'b1;
        cyc(6'b0, 0, 0, 0);
        chk("R1 status after reset", status_o, 8'h00);
        chk("R1 irq after reset", {7'b0, irq_o}, 8'h00);

        // live level, mask still zero
        cyc(6'b000001, 0, 0, 0);
        chk("R3 rx level same cycle", status_o, 8'h01);
        chk("R9 masked off", {7'b0, irq_o}, 8'h00);
        cyc(6'b000001, 1, 1, 8'h3F);
        cyc(6'b000001, 0, 0, 0);
        chk("R7 mask loaded", mask_o, 8'h3F);
        chk("R8 irq raised", {7'b0, irq_o}, 8'h01);

        // writing ones to level bits changes nothing
        cyc(6'b101011, 1, 0, 8'hEB);
        cyc(6'b101011, 0, 0, 0);
        chk("R3 levels ignore ack", status_o, 8'h2B);
        chk("R7 status write keeps mask", mask_o, 8'h3F);

        // drained pulse
        cyc(6'b000100, 0, 0, 0);
        chk("R4 not yet latched", status_o, 8'h00);
        cyc(6'b000000, 0, 0, 0);
        chk("R4 latched", status_o, 8'h04);
        cyc(6'b000000, 0, 0, 0);
        chk("R4 held", status_o, 8'h04);
        cyc(6'b000000, 1, 0, 8'h10);
        cyc(6'b000000, 0, 0, 0);
        chk("R5 other bit ack leaves bit", status_o, 8'h04);
        cyc(6'b000000, 1, 0, 8'h04);
        cyc(6'b000000, 0, 0, 0);
        chk("R5 ack clears", status_o, 8'h00);

        // overrun with coincident ack
        cyc(6'b010000, 0, 0, 0);
        cyc(6'b010000, 1, 0, 8'h10);
        cyc(6'b000000, 0, 0, 0);
        chk("R6 event beats ack", status_o, 8'h10);
        cyc(6'b000000, 1, 0, 8'h10);
        cyc(6'b000000, 0, 0, 0);
        chk("R5 overrun ack clears", status_o, 8'h00);

        // mask zero while pending
        cyc(6'b010101, 0, 0, 0);
        cyc(6'b000001, 1, 1, 8'h00);
        cyc(6'b000001, 0, 0, 0);
        chk("R9 status still pending", status_o, 8'h15);
        chk("R9 irq held low", {7'b0, irq_o}, 8'h00);
        cyc(6'b000001, 1, 1, 8'h10);
        cyc(6'b000000, 0, 0, 0);
        chk("R8 restore mask raises irq", {7'b0, irq_o}, 8'h01);

        // random mix, checked every cycle by the model
        for (int i = 0; i < 400; i++) begin
            logic [5:0] s6;
            s6 = 6'($urandom);
            s6[2] = ($urandom % 4) == 0;
            s6[4] = ($urandom % 4) == 0;
            cyc(s6, ($urandom % 3) == 0, 1'($urandom), 8'($urandom));
        end
        cyc(6'b0, 0, 0, 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(PER * 20000);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule